// File: doc/BRIEF.md
# Per-Wave Ordered-Section Controller

This block follows a single shader wave through its ordered section. Software first writes a small packer register image. Setting the enable bit arms the wave. The wave then waits for a grant from an external ordering gate. Once granted, it runs inside the section until it asks to leave. The exit is handed on to the rest of the chip as a one-cycle done strobe, sent at most once per wave.

The strobe is held back until every outstanding memory counter reports zero. An exit that arrives too early is remembered and completed later. This covers an exit that comes before the grant, or one that comes while counters are still busy. The block also checks how the wave ends. Ending the program while armed or inside, with no done sent, sets a sticky error. A combined end drains the counters, sends done and finishes the wave in one operation. A wave start clears everything for the next wave.

Top module: `ordsec_ctrl`

## Requirements
- R1: After `rst` or `wave_start` is sampled high, the next cycle shows `packer_q` = 0, `done_msg` = 0 and `err` = 0, with the wave idle. `wave_start` takes priority over every other input.
- R2: A write (`cfg_we`) while idle loads `cfg_wdata` into `packer_q` one cycle later. Bit 0 is the enable and bits 2:1 are the packer ID. A write with bit 0 = 1 arms the wave. After that, every further write is ignored until the next wave start, whether it repeats the value or changes it.
- R3: `grant` moves an armed wave to inside. `grant` has no effect while idle, so a later exit without a new grant sends no done.
- R4: `done_msg` is never raised before the grant has been taken. An exit while armed is latched, and done follows on the first cycle in which the wave is inside with counters drained.
- R5: Done needs all three bits of `cnt_zero` high in the same cycle. An exit with any bit low is latched. `done_msg` rises the cycle after the edge at which all three bits are high.
- R6: `done_msg` is a single-cycle pulse and occurs at most once per wave. Later exit requests are ignored.
- R7: An exit request while idle (packer never enabled) produces no done.
- R8: `end_prog` while armed or inside raises `err` on the next cycle, unless done issues at that same edge. `err` then stays high until `wave_start` or `rst`. `end_prog` while idle or after done leaves `err` low.
- R9: `end_ordered` while inside sends done once counters drain, leaves `err` low, and finishes the wave. `end_ordered` while idle finishes the wave with no done. After either, writes and exits are ignored until `wave_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_start | input | 1 | New wave, return to idle |
| cfg_we | input | 1 | Packer register write strobe |
| cfg_wdata | input | 3 | Packer register value, bit 0 enable, bits 2:1 ID |
| grant | input | 1 | Ordering gate allows entry |
| cnt_zero | input | 3 | Per-counter drained flags |
| exit_req | input | 1 | Request to leave the ordered section |
| end_prog | input | 1 | Plain end of program |
| end_ordered | input | 1 | Combined drain, done and end |
| done_msg | output | 1 | One-cycle done message strobe |
| packer_q | output | 3 | Packer register image |
| err | output | 1 | Sticky illegal-end flag |

## Verification
A state that is out of step with the ports shows up quickly. A missing or extra `done_msg` pulse appears one cycle after the edge that should or should not have fired. A stale or overwritten `packer_q` appears one cycle after the write. A lost exit latch shows up as no pulse after the grant or after the counters drain. An error flag wrongly set or cleared appears on the cycle after the end operation. The bench checks the outputs on every cycle, so each such mistake is caught within one cycle of the edge that caused it.

// File: rtl/ordsec_pkg.sv
package ordsec_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ARMED  = 3'd1,
    S_INSIDE = 3'd2,
    S_SENT   = 3'd3,
    S_FIN    = 3'd4
  } ordsec_state_t;
endpackage

// File: rtl/ordsec_packer.sv
module ordsec_packer #(
  parameter int ID_W  = 2,
  localparam int REG_W = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             accept,
  input  logic [REG_W-1:0] wdata,
  input  logic             locked,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (accept) q <= wdata;
  end

  assert_image_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (locked && !clr) |=> $stable(q));
endmodule

// File: rtl/ordsec_drain.sv
module ordsec_drain #(
  parameter int NCNT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            arm,
  input  logic            open,
  input  logic            exit_in,
  input  logic [NCNT-1:0] cnt_zero,
  output logic            pend_q,
  output logic            fire
);
  logic drained;
  assign drained = &cnt_zero;
  assign fire    = open && (pend_q || exit_in) && drained;

  always_ff @(posedge clk) begin
    if (rst || clr) pend_q <= 1'b0;
    else if (fire) pend_q <= 1'b0;
    else if (arm && exit_in) pend_q <= 1'b1;
  end

  assert_latch_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr && !fire) |=> pend_q);
endmodule

// File: rtl/ordsec_ctrl.sv
module ordsec_ctrl
  import ordsec_pkg::*;
#(
  parameter int ID_W  = 2,
  parameter int NCNT  = 3,
  localparam int REG_W = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wave_start,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             grant,
  input  logic [NCNT-1:0]  cnt_zero,
  input  logic             exit_req,
  input  logic             end_prog,
  input  logic             end_ordered,
  output logic             done_msg,
  output logic [REG_W-1:0] packer_q,
  output logic             err
);
  ordsec_state_t state;
  logic end_pend;
  logic pend_q, fire;
  logic accept, locked, arm, open, exit_in;

  assign accept  = cfg_we && (state == S_IDLE);
  assign locked  = (state != S_IDLE);
  assign arm     = (state == S_ARMED) || (state == S_INSIDE);
  assign open    = (state == S_INSIDE);
  assign exit_in = exit_req || end_ordered;

  ordsec_packer #(.ID_W(ID_W)) u_packer (
    .clk(clk), .rst(rst), .clr(wave_start), .accept(accept),
    .wdata(cfg_wdata), .locked(locked), .q(packer_q)
  );

  ordsec_drain #(.NCNT(NCNT)) u_drain (
    .clk(clk), .rst(rst), .clr(wave_start), .arm(arm), .open(open),
    .exit_in(exit_in), .cnt_zero(cnt_zero), .pend_q(pend_q), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst || wave_start) begin
      state    <= S_IDLE;
      end_pend <= 1'b0;
      done_msg <= 1'b0;
      err      <= 1'b0;
    end else begin
      done_msg <= fire;
      if (arm && end_ordered) end_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (end_prog || end_ordered) state <= S_FIN;
          else if (cfg_we && cfg_wdata[0]) state <= S_ARMED;
        end
        S_ARMED: begin
          if (end_prog) begin
            state <= S_FIN;
            err   <= 1'b1;
          end else if (grant) state <= S_INSIDE;
        end
        S_INSIDE: begin
          if (end_prog) begin
            state <= S_FIN;
            if (!fire) err <= 1'b1;
          end else if (fire) begin
            state <= (end_pend || end_ordered) ? S_FIN : S_SENT;
          end
        end
        S_SENT: if (end_prog || end_ordered) state <= S_FIN;
        S_FIN: state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_wave_clear_R1: assert property (@(posedge clk) disable iff (rst)
    wave_start |=> (packer_q == '0 && !done_msg && !err));
  assert_no_early_done_R4: assert property (@(posedge clk) disable iff (rst)
    done_msg |-> ($past(state) == S_INSIDE));
  assert_drained_done_R5: assert property (@(posedge clk) disable iff (rst)
    done_msg |-> $past(&cnt_zero));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (done_msg && !wave_start) |=> !done_msg);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err && !wave_start) |=> err);
endmodule

// File: tb/tb_ordsec_ctrl.sv
`timescale 1ns/1ps
module tb_ordsec_ctrl;
  localparam int CLK_HALF = 4;

  logic clk = 1'b0;
  logic rst, wave_start, cfg_we, grant, exit_req, end_prog, end_ordered;
  logic [2:0] cfg_wdata, cnt_zero;
  logic done_msg, err;
  logic [2:0] packer_q;

  always #CLK_HALF clk = ~clk;

  ordsec_ctrl dut (
    .clk(clk), .rst(rst), .wave_start(wave_start), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .grant(grant), .cnt_zero(cnt_zero),
    .exit_req(exit_req), .end_prog(end_prog), .end_ordered(end_ordered),
    .done_msg(done_msg), .packer_q(packer_q), .err(err)
  );

  typedef struct {
    logic       d;
    logic [2:0] p;
    logic       e;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic s_rst, s_ws, s_we, s_gr, s_ex, s_ep, s_eo;
  logic [2:0] s_wd, s_cz;

  task automatic stage_clear();
    s_rst = 0; s_ws = 0; s_we = 0; s_gr = 0; s_ex = 0; s_ep = 0; s_eo = 0;
    s_wd = 3'b000; s_cz = 3'b111;
  endtask

  // Apply staged inputs for one cycle; push outputs expected after that edge.
  task automatic cyc(input logic d, input logic [2:0] p, input logic e, input string tag);
    exp_t it;
    @(negedge clk);
    #1;
    rst = s_rst; wave_start = s_ws; cfg_we = s_we; cfg_wdata = s_wd;
    grant = s_gr; exit_req = s_ex; end_prog = s_ep; end_ordered = s_eo;
    cnt_zero = s_cz;
    it.d = d; it.p = p; it.e = e; it.tag = tag;
    exp_q.push_back(it);
    stage_clear();
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (done_msg !== it.d || packer_q !== it.p || err !== it.e) begin
        fails++;
        $display("FAIL %s: got done=%b pk=%b err=%b, expected done=%b pk=%b err=%b",
                 it.tag, done_msg, packer_q, err, it.d, it.p, it.e);
      end
    end
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; wave_start = 0; cfg_we = 0; cfg_wdata = 0; grant = 0;
    exit_req = 0; end_prog = 0; end_ordered = 0; cnt_zero = 3'b111;
    stage_clear();
    s_rst = 1; cyc(0, 3'd0, 0, "R1 reset");
    s_rst = 1; cyc(0, 3'd0, 0, "R1 reset hold");
    // R7: exit while idle
    s_ex = 1; cyc(0, 3'd0, 0, "R7 idle exit");
    cyc(0, 3'd0, 0, "R7 idle after exit");
    // R3: grant while idle ignored
    s_gr = 1; cyc(0, 3'd0, 0, "R3 idle grant");
    // R2: writes
    s_we = 1; s_wd = 3'b010; cyc(0, 3'd2, 0, "R2 write disabled");
    s_we = 1; s_wd = 3'b101; cyc(0, 3'd5, 0, "R2 write enable");
    s_we = 1; s_wd = 3'b101; cyc(0, 3'd5, 0, "R2 repeat write");
    s_we = 1; s_wd = 3'b011; cyc(0, 3'd5, 0, "R2 changed write ignored");
    // R4: exit before grant latched
    s_ex = 1; cyc(0, 3'd5, 0, "R4 exit armed");
    cyc(0, 3'd5, 0, "R4 waiting");
    s_gr = 1; cyc(0, 3'd5, 0, "R4 grant edge");
    cyc(1, 3'd5, 0, "R4 done after grant");
    cyc(0, 3'd5, 0, "R6 pulse ends");
    s_ex = 1; cyc(0, 3'd5, 0, "R6 second exit");
    s_ep = 1; cyc(0, 3'd5, 0, "R8 end after done");
    // R5: drain gating
    s_ws = 1; cyc(0, 3'd0, 0, "R1 wave start");
    s_we = 1; s_wd = 3'b011; cyc(0, 3'd3, 0, "R2 arm id1");
    s_gr = 1; cyc(0, 3'd3, 0, "R3 grant");
    s_ex = 1; s_cz = 3'b101; cyc(0, 3'd3, 0, "R5 exit busy");
    s_cz = 3'b011; cyc(0, 3'd3, 0, "R5 busy");
    s_cz = 3'b110; cyc(0, 3'd3, 0, "R5 busy2");
    cyc(1, 3'd3, 0, "R5 drained done");
    s_ex = 1; cyc(0, 3'd3, 0, "R6 no repeat");
    // R8: plain end while armed
    s_ws = 1; cyc(0, 3'd0, 0, "R1 wave start2");
    s_we = 1; s_wd = 3'b101; cyc(0, 3'd5, 0, "R2 arm");
    s_ep = 1; cyc(0, 3'd5, 1, "R8 illegal end");
    cyc(0, 3'd5, 1, "R8 sticky");
    s_ex = 1; cyc(0, 3'd5, 1, "R8 exit after end");
    // R9: combined end inside
    s_ws = 1; cyc(0, 3'd0, 0, "R1 err cleared");
    s_we = 1; s_wd = 3'b011; cyc(0, 3'd3, 0, "R9 arm");
    s_gr = 1; cyc(0, 3'd3, 0, "R9 grant");
    s_eo = 1; s_cz = 3'b000; cyc(0, 3'd3, 0, "R9 combined busy");
    s_cz = 3'b000; cyc(0, 3'd3, 0, "R9 busy");
    cyc(1, 3'd3, 0, "R9 combined done");
    s_ex = 1; cyc(0, 3'd3, 0, "R9 exit after end");
    s_ep = 1; cyc(0, 3'd3, 0, "R9 end after finish");
    // R9: combined end idle
    s_ws = 1; cyc(0, 3'd0, 0, "R1 wave start3");
    s_eo = 1; cyc(0, 3'd0, 0, "R9 combined idle");
    s_we = 1; s_wd = 3'b011; cyc(0, 3'd0, 0, "R9 write after finish");
    // R8: end with simultaneous done is legal
    s_ws = 1; cyc(0, 3'd0, 0, "R1 wave start4");
    s_we = 1; s_wd = 3'b101; cyc(0, 3'd5, 0, "R2 arm again");
    s_gr = 1; cyc(0, 3'd5, 0, "R3 grant again");
    s_ep = 1; s_ex = 1; cyc(1, 3'd5, 0, "R8 end with done");
    // R8: plain end inside
    s_ws = 1; cyc(0, 3'd0, 0, "R1 wave start5");
    s_we = 1; s_wd = 3'b101; cyc(0, 3'd5, 0, "R2 arm5");
    s_gr = 1; cyc(0, 3'd5, 0, "R3 grant5");
    s_ep = 1; cyc(0, 3'd5, 1, "R8 end inside");
    // R3: grant in idle then exit with no grant
    s_ws = 1; cyc(0, 3'd0, 0, "R1 wave start6");
    s_gr = 1; cyc(0, 3'd0, 0, "R3 early grant");
    s_we = 1; s_wd = 3'b101; cyc(0, 3'd5, 0, "R3 arm");
    s_ex = 1; cyc(0, 3'd5, 0, "R3 exit no grant");
    cyc(0, 3'd5, 0, "R3 still no done");
    @(negedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule